// File: doc/BRIEF.md
# Lock and Fuse Access Window Controller

This block sits beside the program-memory path of a small microcontroller and owns the nonvolatile boot lock bits. Software writes a control value to arm a short access window. A store-program strobe inside that window programs boot lock bits from a data byte. A load-program strobe inside the window returns the lock byte or one of two fuse bytes, chosen by the pointer. Once the window has closed, store and load strobes are ordinary program-memory accesses. The block passes the memory byte through on loads.

The lock state also guards those ordinary accesses. Two of the boot lock bits select a protection mode, and the mode can forbid stores into the boot section, or loads into the boot section from code that runs in the application section. A refused load returns all ones, and any refused access raises a one-cycle denial flag. The boot section is every pointer value at or above `BOOT_BASE`. When the upper boot lock bit is programmed and code runs from the boot section, the block asks the core to hold interrupts off.

Top module: `lockfuse_window`

## Requirements
- R1: A control write whose bits 3 and 0 are both 1 opens a window. A store strobe on the 1st to 4th clock edge after the control-write edge programs lock bits. A store strobe on any later edge leaves the lock bits unchanged.
- R2: On a lock-programming store, a 0 in st_data bit 5, 4, 3 or 2 programs boot lock bit BLB12, BLB11, BLB02 or BLB01 respectively, and a 1 changes nothing. A programmed bit is never unprogrammed by any store.
- R3: A load strobe on the 1st to 5th edge after arming returns a byte selected by the pointer: 0x0001 gives the lock byte, 0x0000 gives fuse low, 0x0003 gives fuse high, and any other pointer gives 0xFF.
- R4: The lock byte is {1,1,BLB12,BLB11,BLB02,BLB01,LB_BITS}, where programmed reads 0. Unused fuse positions read 1: bit 4 of fuse low and bits 7..3 of fuse high.
- R5: The window closes after a lock-programming store or an armed load completes, or after the 5th edge with no such access. After that, a permitted load returns mem_rdata.
- R6: While BLB11 is programmed, an ordinary store with the pointer in the boot section raises denied with rd_valid low. With BLB11 unprogrammed, such a store is not denied.
- R7: While BLB12 is programmed, an ordinary load into the boot section with in_boot low returns 0xFF with denied high. The same load with in_boot high returns mem_rdata.
- R8: irq_off is high exactly when BLB12 is programmed and in_boot is high.
- R9: A new arming write inside an open window restarts the window count from that write.
- R10: After reset all four boot lock bits are unprogrammed and rd_valid and denied are low. Each load or store result appears for the single cycle after the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value; bit 3 selects lock access, bit 0 enables |
| st_data | input | 8 | Data byte for lock programming |
| ptr | input | PTR_W | Program pointer (select on armed loads, target otherwise) |
| st_strobe | input | 1 | Store-program instruction strobe |
| ld_strobe | input | 1 | Load-program instruction strobe |
| in_boot | input | 1 | Executing code lies in the boot section |
| mem_rdata | input | 8 | Program memory byte for ordinary loads |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 8 | Load result byte |
| denied | output | 1 | Access refused by boot protection |
| irq_off | output | 1 | Interrupts must be held off |

## Verification
The load and store results are registered. rd_valid, rd_data and denied belong to the cycle after the edge that samples the strobe. The monitor therefore captures at each rising edge whether a strobe was sampled, waits 1 ns and pops the expected item for that edge. Window timing is set by strobing on the exact edge number after arming: edge 4 against 5 for stores, edge 5 against 6 for loads, and edge 7 after a restart. irq_off is combinational, so it is checked 1 ns after in_boot changes.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

    localparam int CTL_SEL_BIT = 3;
    localparam int CTL_EN_BIT  = 0;
    localparam logic [7:0] FLO_UNUSED = 8'h10;
    localparam logic [7:0] FHI_UNUSED = 8'hF8;

    typedef struct packed {
        logic blb12;
        logic blb11;
        logic blb02;
        logic blb01;
    } boot_lock_t;

    typedef enum logic [1:0] {
        PROT_ALL      = 2'b00,
        PROT_NO_LOAD  = 2'b01,
        PROT_NO_STORE = 2'b10,
        PROT_NONE     = 2'b11
    } prot_mode_t;

    typedef enum logic [1:0] {
        SRC_FUSE_LO,
        SRC_LOCK,
        SRC_FUSE_HI,
        SRC_NONE
    } rd_src_t;

    typedef struct packed {
        logic       valid;
        logic       deny;
        logic [7:0] data;
    } rd_result_t;

    function automatic rd_src_t pick_src(input logic upper_zero, input logic [1:0] low);
        if (!upper_zero) return SRC_NONE;
        case (low)
            2'd0:    return SRC_FUSE_LO;
            2'd1:    return SRC_LOCK;
            2'd3:    return SRC_FUSE_HI;
            default: return SRC_NONE;
        endcase
    endfunction

    function automatic logic [7:0] lock_byte(input boot_lock_t lk, input logic [1:0] lb);
        return {2'b11, lk, lb};
    endfunction

endpackage

// File: rtl/lfw_window.sv
module lfw_window #(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_we,
    input  logic arm_val,
    input  logic consume,
    output logic st_open,
    output logic ld_open
);
    localparam int AW = $clog2(LOAD_WIN + 1);

    logic          armed;
    logic [AW-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            age   <= '0;
        end else if (ctl_we) begin
            armed <= arm_val;
            age   <= AW'(1);
        end else if (consume) begin
            armed <= 1'b0;
        end else if (armed) begin
            if (age == AW'(LOAD_WIN)) armed <= 1'b0;
            else                      age   <= age + AW'(1);
        end
    end

    assign st_open = armed && (age <= AW'(STORE_WIN));
    assign ld_open = armed && (age <= AW'(LOAD_WIN));
endmodule

// File: rtl/lfw_lockbank.sv
module lfw_lockbank
    import lfw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       prog,
    input  logic [3:0] pattern,
    output boot_lock_t lk_q
);
    always_ff @(posedge clk) begin
        if (rst)       lk_q <= '1;
        else if (prog) lk_q <= lk_q & pattern;
    end
endmodule

// File: rtl/lfw_guard.sv
module lfw_guard
    import lfw_pkg::*;
(
    input  boot_lock_t lk,
    input  logic       in_boot,
    input  logic       tgt_boot,
    output logic       store_block,
    output logic       load_block,
    output logic       irq_off
);
    prot_mode_t mode;
    logic       no_store, no_app_load;

    always_comb begin
        mode = prot_mode_t'({lk.blb12, lk.blb11});
        unique case (mode)
            PROT_NONE:     begin no_store = 1'b0; no_app_load = 1'b0; end
            PROT_NO_STORE: begin no_store = 1'b1; no_app_load = 1'b0; end
            PROT_ALL:      begin no_store = 1'b1; no_app_load = 1'b1; end
            default:       begin no_store = 1'b0; no_app_load = 1'b1; end
        endcase
    end

    assign store_block = tgt_boot && no_store;
    assign load_block  = tgt_boot && !in_boot && no_app_load;
    assign irq_off     = in_boot && !lk.blb12;
endmodule

// File: rtl/lockfuse_window.sv
module lockfuse_window
    import lfw_pkg::*;
#(
    parameter int             PTR_W     = 16,
    parameter logic [PTR_W-1:0] BOOT_BASE = 16'hF000,
    parameter logic [7:0]     FUSE_LO   = 8'hA2,
    parameter logic [7:0]     FUSE_HI   = 8'h05,
    parameter logic [1:0]     LB_BITS   = 2'b10,
    parameter int             STORE_WIN = 4,
    parameter int             LOAD_WIN  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic [7:0]       st_data,
    input  logic [PTR_W-1:0] ptr,
    input  logic             st_strobe,
    input  logic             ld_strobe,
    input  logic             in_boot,
    input  logic [7:0]       mem_rdata,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             denied,
    output logic             irq_off
);
    logic       arm_val, st_open, ld_open, lock_wr, armed_ld, consume;
    logic       tgt_boot, store_block, load_block;
    boot_lock_t lk_q;
    rd_src_t    src;
    rd_result_t res_d, res_q;

    assign arm_val  = ctl_wdata[CTL_SEL_BIT] & ctl_wdata[CTL_EN_BIT];
    assign lock_wr  = st_strobe && st_open;
    assign armed_ld = ld_strobe && !st_strobe && ld_open;
    assign consume  = lock_wr || armed_ld;
    assign tgt_boot = (ptr >= BOOT_BASE);
    assign src      = pick_src(ptr[PTR_W-1:2] == '0, ptr[1:0]);

    lfw_window #(.STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) u_win (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .arm_val(arm_val),
        .consume(consume), .st_open(st_open), .ld_open(ld_open)
    );

    lfw_lockbank u_bank (
        .clk(clk), .rst(rst), .prog(lock_wr), .pattern(st_data[5:2]), .lk_q(lk_q)
    );

    lfw_guard u_guard (
        .lk(lk_q), .in_boot(in_boot), .tgt_boot(tgt_boot),
        .store_block(store_block), .load_block(load_block), .irq_off(irq_off)
    );

    always_comb begin
        res_d = '0;
        if (st_strobe) begin
            if (!st_open) res_d.deny = store_block;
        end else if (ld_strobe) begin
            res_d.valid = 1'b1;
            if (ld_open) begin
                unique case (src)
                    SRC_LOCK:    res_d.data = lock_byte(lk_q, LB_BITS);
                    SRC_FUSE_LO: res_d.data = FUSE_LO | FLO_UNUSED;
                    SRC_FUSE_HI: res_d.data = FUSE_HI | FHI_UNUSED;
                    default:     res_d.data = 8'hFF;
                endcase
            end else if (load_block) begin
                res_d.deny = 1'b1;
                res_d.data = 8'hFF;
            end else begin
                res_d.data = mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign rd_valid = res_q.valid;
    assign rd_data  = res_q.data;
    assign denied   = res_q.deny;
endmodule

// File: rtl/lfw_checker.sv
module lfw_checker #(
    parameter int LOAD_WIN = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic       st_strobe,
    input logic       ld_strobe,
    input logic       in_boot,
    input logic       ld_open,
    input logic [3:0] blb,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       denied,
    input logic       irq_off
);
    localparam int CW = $clog2(LOAD_WIN + 2) + 1;

    logic          past_ok;
    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            since   <= '0;
        end else begin
            past_ok <= 1'b1;
            if (ctl_we)           since <= CW'(1);
            else if (since != '1) since <= since + CW'(1);
        end
    end

    AST_LOCK_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((blb & ~$past(blb)) == 4'b0)); // R2
    AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ld_open |-> (since <= CW'(LOAD_WIN))); // R5
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (in_boot && !blb[3]) |-> irq_off); // R8
    AST_IRQ_APP_FREE: assert property (@(posedge clk) disable iff (rst)
        !in_boot |-> !irq_off); // R8
    AST_DENY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && denied) |-> $past(st_strobe || ld_strobe)); // R10
    AST_DENY_DATA: assert property (@(posedge clk) disable iff (rst)
        (denied && rd_valid) |-> (rd_data == 8'hFF)); // R7
endmodule

bind lockfuse_window lfw_checker #(.LOAD_WIN(LOAD_WIN)) u_chk (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .st_strobe(st_strobe),
    .ld_strobe(ld_strobe), .in_boot(in_boot), .ld_open(ld_open),
    .blb(lk_q), .rd_valid(rd_valid), .rd_data(rd_data),
    .denied(denied), .irq_off(irq_off)
);

// File: tb/lockfuse_window_bench.sv
module lockfuse_window_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  st_data = 8'hFF;
    logic [15:0] ptr = '0;
    logic        st_strobe = 1'b0;
    logic        ld_strobe = 1'b0;
    logic        in_boot = 1'b0;
    logic [7:0]  mem_rdata = 8'h5A;
    logic        rd_valid, denied, irq_off;
    logic [7:0]  rd_data;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        string      req;
        logic       valid;
        logic       deny;
        logic [7:0] data;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    lockfuse_window u_lockfuse_window (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .st_data(st_data), .ptr(ptr), .st_strobe(st_strobe),
        .ld_strobe(ld_strobe), .in_boot(in_boot), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .denied(denied), .irq_off(irq_off)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: results are due one edge after the sampled strobe
    initial begin
        forever begin
            bit s;
            @(posedge clk);
            s = st_strobe | ld_strobe;
            #1;
            if (s && !rst) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk(1'b0, "scoreboard-empty", 0, 1);
                end else begin
                    e = sb.pop_front();
                    chk(rd_valid == e.valid && denied == e.deny &&
                        (!e.valid || rd_data == e.data), e.req,
                        {rd_valid, denied, rd_data}, {e.valid, e.deny, e.data});
                end
            end
        end
    end

    task automatic arm(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_store(input logic [7:0] d, input logic [15:0] p,
                            input string req, input logic exp_deny);
        exp_t e;
        st_data = d; ptr = p; st_strobe = 1'b1;
        e.req = req; e.valid = 1'b0; e.deny = exp_deny; e.data = 8'h00;
        sb.push_back(e);
        @(negedge clk); st_strobe = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] p, input logic boot, input string req,
                           input logic exp_deny, input logic [7:0] exp_data);
        exp_t e;
        ptr = p; in_boot = boot; ld_strobe = 1'b1;
        e.req = req; e.valid = 1'b1; e.deny = exp_deny; e.data = exp_data;
        sb.push_back(e);
        @(negedge clk); ld_strobe = 1'b0; in_boot = 1'b0;
    endtask

    task automatic read_lock(input string req, input logic [7:0] expv);
        arm(8'h09);
        do_load(16'h0001, 1'b0, req, 1'b0, expv);
    endtask

    task automatic irq_check(input logic boot, input logic expv);
        @(negedge clk); in_boot = boot; #1;
        chk(irq_off == expv, "R8 irq_off", irq_off, expv);
        in_boot = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(rd_valid == 0 && denied == 0, "R10 reset outputs", {rd_valid, denied}, 0);
        // R10 lock bits unprogrammed, R4 lock byte layout
        read_lock("R4 R10 lock after reset", 8'hFE);
        // R3 fuse low on 5th edge, unused bit 4 forced high
        arm(8'h09); gap(4); do_load(16'h0000, 1'b0, "R3 R4 fuse low edge5", 1'b0, 8'hB2);
        arm(8'h09); do_load(16'h0003, 1'b0, "R3 R4 fuse high", 1'b0, 8'hFD);
        arm(8'h09); do_load(16'h0002, 1'b0, "R3 unused pointer", 1'b0, 8'hFF);
        // R5 6th edge: window gone, ordinary load
        arm(8'h09); gap(5); do_load(16'h0001, 1'b0, "R5 load after expiry", 1'b0, 8'h5A);
        // R5 completion closes the window
        arm(8'h09); do_load(16'h0001, 1'b0, "R5 first armed read", 1'b0, 8'hFE);
        do_load(16'h0000, 1'b0, "R5 second read ordinary", 1'b0, 8'h5A);
        // R1 store on 4th edge programs BLB11
        arm(8'h09); gap(3); do_store(8'hEF, 16'h0001, "R1 store edge4", 1'b0);
        read_lock("R1 R2 lock after BLB11", 8'hEE);
        // R1 store on 5th edge ignored
        arm(8'h09); gap(4); do_store(8'hC3, 16'h0001, "R1 late store", 1'b0);
        read_lock("R1 lock unchanged by late store", 8'hEE);
        // R2 ones never unprogram
        arm(8'h09); do_store(8'hFF, 16'h0001, "R2 store all ones", 1'b0);
        read_lock("R2 no unprogramming", 8'hEE);
        // R6 store-only protection
        do_store(8'h00, 16'hF010, "R6 boot store denied", 1'b1);
        do_store(8'h00, 16'h0100, "R6 app store allowed", 1'b0);
        do_load(16'hF010, 1'b0, "R7 load allowed under store-only", 1'b0, 8'h5A);
        irq_check(1'b1, 1'b0);
        // R9 re-arm: store on 7th edge after first arm, 4th after second
        arm(8'h09); gap(2); arm(8'h09); gap(3);
        do_store(8'hD7, 16'h0001, "R9 store after restart", 1'b0);
        read_lock("R9 lock after restart store", 8'hC6);
        // R7 full protection
        do_load(16'hF020, 1'b0, "R7 app load denied", 1'b1, 8'hFF);
        mem_rdata = 8'h3C;
        do_load(16'hF020, 1'b1, "R7 boot load allowed", 1'b0, 8'h3C);
        do_store(8'h00, 16'hF020, "R6 boot store denied mode00", 1'b1);
        irq_check(1'b1, 1'b1);
        irq_check(1'b0, 1'b0);
        // reset, then load-only protection
        @(negedge clk); rst = 1'b1; gap(2); rst = 1'b0;
        read_lock("R10 lock after second reset", 8'hFE);
        arm(8'h09); do_store(8'hDF, 16'h0001, "R2 program BLB12", 1'b0);
        read_lock("R2 lock BLB12 only", 8'hDE);
        do_store(8'h00, 16'hF030, "R6 boot store allowed mode01", 1'b0);
        do_load(16'hF030, 1'b0, "R7 app load denied mode01", 1'b1, 8'hFF);
        gap(2);
        chk(sb.size() == 0, "R10 all results seen", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule